// File: doc/BRIEF.md
# DMA Channel Control/Status Word with Interrupt Combiner

This block is the single 32-bit control and status word of a one-channel DMA engine that serves a SCSI-style peripheral. A small register bus (address, write enable, write data, read strobe, read data) reaches it. The word mixes several kinds of bits:

- Read-write control fields: interrupt enables, engine reset, direction, engine enable, parity enable, auto-drain and burst size.
- Sticky status flags: memory error, transfer-count-zero, parity error and slave-size error.
- Write-one action bits: flush and drain. These emit one-cycle strobes toward the packing buffer and the flag logic.
- A fixed device-ID nibble.

The datapath counters and the packing buffer sit outside the block. Their events arrive as single-cycle input pulses. The block combines the peripheral's interrupt line, the gated transfer-count-zero flag and the gated parity-error flag into a summary bit. When interrupts are enabled, it drives a registered interrupt output from that summary, or from a pending memory error.

Top module: `dma_csr_top`

## Requirements
- R1: After synchronous reset, a read of the word returns only the device ID in bits 31:28. `irq_out`, `eng_reset`, `eng_enable`, `dir_to_mem`, `drain_stb`, `flush_stb` are 0 and `burst_mode` is 00.
- R2: Bit 0 shows the peripheral interrupt input, sampled into a register, so it follows the line one cycle later and clears when the line drops.
- R3: A `mem_err` pulse sets bit 1 (error pending), which holds until cleared.
- R4: Writing 1 to bit 5 (flush) has three effects. It clears bits 1, 12 and 16 at that write edge. It pulses `flush_stb` for exactly one cycle after the write. Bit 5 always reads 0. An event pulse in the same cycle as the flush wins.
- R5: A `size_err` pulse sets bit 6. Any read of the word returns the flag and then clears it, unless a new pulse arrives in the same cycle as the read.
- R6: Bits 4 (interrupt enable), 7 (engine reset), 8 (direction, 1 = toward memory), 9 (engine enable), 13 (count-zero interrupt enable), 15 (parity enable), 18 (auto-drain) and 21:20 (burst) are read-write. `eng_reset` follows bit 7, `dir_to_mem` follows bit 8, and `eng_enable` is bit 9 while bit 7 is 0.
- R7: Bit 14 (summary) reads as bit 0 OR (bit 12 AND bit 13) OR (bit 16 AND bit 15). Bit 12 is set by `tc_zero` and bit 16 by `parity_err`.
- R8: One cycle after the state changes, `irq_out` equals bit 4 AND (bit 14 OR bit 1).
- R9: The burst field in bits 21:20 reads back as written. `burst_mode` decodes it as 00 = 16-byte, 01 = 32-byte, 10 = single transfers, and the reserved value 11 drives 00.
- R10: Writing 1 to bit 17 (drain) pulses `drain_stb` for one cycle after the write, but only if bit 18 held 0 before that write. Bit 17 always reads 0.
- R11: Bits 31:28 read as parameter DEV_ID (default 0xA), and writes do not change them. Bits 2, 3, 10, 11, 19, 27:22 read 0.
- R12: An access whose address differs from CSR_ADDR (default 0) has no effect on the word. Such a write changes nothing. Such a read returns 0 and does not clear bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write enable |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| dev_irq | input | 1 | Peripheral interrupt line |
| mem_err | input | 1 | Memory exception pulse |
| size_err | input | 1 | Slave-size error pulse |
| tc_zero | input | 1 | Transfer count reached zero pulse |
| parity_err | input | 1 | Bus parity error pulse |
| irq_out | output | 1 | Registered interrupt request |
| eng_reset | output | 1 | Engine held in reset |
| eng_enable | output | 1 | Engine answers DMA requests |
| dir_to_mem | output | 1 | Transfer direction, 1 = toward memory |
| burst_mode | output | 2 | Decoded burst size |
| drain_stb | output | 1 | One-cycle drain request to packing buffer |
| flush_stb | output | 1 | One-cycle flush request to packing buffer |

## Verification
The interrupt combiner is swept over all 128 combinations of these inputs: the peripheral line, count-zero flag and its enable, parity flag and its enable, error pending and the master enable. This separates a source that is gated by the wrong enable, or not gated at all, from the correct OR-of-ANDs. It also shows whether the error flag bypasses the summary bit. All four burst codes are written, so a reserved code that leaks to the output stands out. Drain is tried with auto-drain both clear and set. Slave-error reads are paired with reads at a foreign address, which tells clear-on-any-read apart from clear-on-hit.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int WORD_W = 32;

  // Bit positions inside the word (software decodes these)
  localparam int B_DEVINT = 0;
  localparam int B_ERR    = 1;
  localparam int B_INTEN  = 4;
  localparam int B_FLUSH  = 5;
  localparam int B_SLV    = 6;
  localparam int B_RST    = 7;
  localparam int B_DIR    = 8;
  localparam int B_EN     = 9;
  localparam int B_TCZ    = 12;
  localparam int B_TCEN   = 13;
  localparam int B_SUM    = 14;
  localparam int B_PEN    = 15;
  localparam int B_PERR   = 16;
  localparam int B_DRAIN  = 17;
  localparam int B_AUTOD  = 18;
  localparam int B_BURST  = 20;
  localparam int B_ID     = 28;
  localparam int ID_W     = 4;

  // Sticky flag indices
  localparam int F_ERR  = 0;
  localparam int F_TCZ  = 1;
  localparam int F_PERR = 2;
  localparam int F_SLV  = 3;
  localparam int NFLAG  = 4;

  typedef enum logic [1:0] {
    BURST_16   = 2'b00,
    BURST_32   = 2'b01,
    BURST_NONE = 2'b10,
    BURST_RSVD = 2'b11
  } burst_e;

  typedef struct packed {
    logic       autodrain;
    logic [1:0] burst;
    logic       pen;
    logic       tcen;
    logic       en;
    logic       dir;
    logic       rst;
    logic       inten;
  } ctrl_t;

  function automatic burst_e burst_norm(input logic [1:0] raw);
    burst_e b;
    b = burst_e'(raw);
    if (b == BURST_RSVD) b = BURST_16;
    return b;
  endfunction
endpackage

// File: rtl/dma_csr_flags.sv
module dma_csr_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  // One sticky bit per source; a set in the same cycle as a clear wins.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic              drain_stb,
  output logic              flush_stb
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d           = ctrl;
    ctrl_d.inten     = wdata[B_INTEN];
    ctrl_d.rst       = wdata[B_RST];
    ctrl_d.dir       = wdata[B_DIR];
    ctrl_d.en        = wdata[B_EN];
    ctrl_d.tcen      = wdata[B_TCEN];
    ctrl_d.pen       = wdata[B_PEN];
    ctrl_d.autodrain = wdata[B_AUTOD];
    ctrl_d.burst     = wdata[B_BURST +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      drain_stb <= 1'b0;
      flush_stb <= 1'b0;
    end else begin
      if (wr_hit) ctrl <= ctrl_d;
      flush_stb <= wr_hit & wdata[B_FLUSH];
      // drain request is dropped while auto-drain is already on
      drain_stb <= wr_hit & wdata[B_DRAIN] & ~ctrl.autodrain;
    end
  end

  assert_drain_gated_R10: assert property (@(posedge clk) disable iff (rst)
    drain_stb |-> !$past(ctrl.autodrain));
  assert_flush_src_R4: assert property (@(posedge clk) disable iff (rst)
    flush_stb |-> $past(wr_hit));
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq (
  input  logic clk,
  input  logic rst,
  input  logic dev_q,
  input  logic tcz,
  input  logic tcen,
  input  logic perr,
  input  logic pen,
  input  logic err,
  input  logic inten,
  output logic summary,
  output logic irq_out
);
  always_comb summary = dev_q | (tcz & tcen) | (perr & pen);

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= inten & (summary | err);
  end

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    !inten |=> !irq_out);
  assert_irq_err_R8: assert property (@(posedge clk) disable iff (rst)
    (inten && err) |=> irq_out);
  assert_irq_dev_R7: assert property (@(posedge clk) disable iff (rst)
    (inten && dev_q) |=> irq_out);
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          CSR_ADDR = 0,
  parameter logic [3:0]  DEV_ID   = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic              dev_irq,
  input  logic              mem_err,
  input  logic              size_err,
  input  logic              tc_zero,
  input  logic              parity_err,
  output logic              irq_out,
  output logic              eng_reset,
  output logic              eng_enable,
  output logic              dir_to_mem,
  output logic [1:0]        burst_mode,
  output logic              drain_stb,
  output logic              flush_stb
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CSR_ADDR);

  logic             hit, wr_hit, rd_hit, flush_now;
  logic             dev_q, summary;
  logic [NFLAG-1:0] fset, fclr, flags;
  ctrl_t            ctrl;
  logic [31:0]      word;

  always_comb begin
    hit       = (addr == HIT_ADDR);
    wr_hit    = wr_en & hit;
    rd_hit    = rd_en & hit;
    flush_now = wr_hit & wr_data[B_FLUSH];
  end

  always_ff @(posedge clk) begin
    if (rst) dev_q <= 1'b0;
    else     dev_q <= dev_irq;
  end

  always_comb begin
    fset         = '0;
    fclr         = '0;
    fset[F_ERR]  = mem_err;
    fset[F_TCZ]  = tc_zero;
    fset[F_PERR] = parity_err;
    fset[F_SLV]  = size_err;
    fclr[F_ERR]  = flush_now;
    fclr[F_TCZ]  = flush_now;
    fclr[F_PERR] = flush_now;
    fclr[F_SLV]  = rd_hit;
  end

  dma_csr_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fset), .clr(fclr), .q(flags)
  );

  dma_csr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(wr_data),
    .ctrl(ctrl), .drain_stb(drain_stb), .flush_stb(flush_stb)
  );

  dma_csr_irq u_irq (
    .clk(clk), .rst(rst), .dev_q(dev_q), .tcz(flags[F_TCZ]), .tcen(ctrl.tcen),
    .perr(flags[F_PERR]), .pen(ctrl.pen), .err(flags[F_ERR]), .inten(ctrl.inten),
    .summary(summary), .irq_out(irq_out)
  );

  always_comb begin
    word                 = '0;
    word[B_DEVINT]       = dev_q;
    word[B_ERR]          = flags[F_ERR];
    word[B_INTEN]        = ctrl.inten;
    word[B_SLV]          = flags[F_SLV];
    word[B_RST]          = ctrl.rst;
    word[B_DIR]          = ctrl.dir;
    word[B_EN]           = ctrl.en;
    word[B_TCZ]          = flags[F_TCZ];
    word[B_TCEN]         = ctrl.tcen;
    word[B_SUM]          = summary;
    word[B_PEN]          = ctrl.pen;
    word[B_PERR]         = flags[F_PERR];
    word[B_AUTOD]        = ctrl.autodrain;
    word[B_BURST +: 2]   = ctrl.burst;
    word[B_ID +: ID_W]   = DEV_ID;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= hit ? word : '0;
  end

  always_comb begin
    eng_reset  = ctrl.rst;
    eng_enable = ctrl.en & ~ctrl.rst;
    dir_to_mem = ctrl.dir;
    burst_mode = burst_norm(ctrl.burst);
  end

  assert_flush_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (flush_now && !mem_err && !tc_zero && !parity_err)
      |=> (!flags[F_ERR] && !flags[F_TCZ] && !flags[F_PERR]));
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !size_err) |=> !flags[F_SLV]);
  assert_foreign_read_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> (rd_data == 32'h0));
  assert_id_field_R11: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data[31:28] == DEV_ID));
  assert_no_rsvd_burst_R9: assert property (@(posedge clk) disable iff (rst)
    burst_mode != 2'b11);
  assert_reset_holds_R6: assert property (@(posedge clk) disable iff (rst)
    eng_reset |-> !eng_enable);
endmodule

// File: tb/tb_dma_csr_top.sv
module tb_dma_csr_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDW = 32'hA000_0000;

  logic        clk = 0;
  logic        rst;
  logic [3:0]  addr;
  logic        wr_en, rd_en;
  logic [31:0] wr_data, rd_data;
  logic        dev_irq, mem_err, size_err, tc_zero, parity_err;
  logic        irq_out, eng_reset, eng_enable, dir_to_mem, drain_stb, flush_stb;
  logic [1:0]  burst_mode;

  int n_chk = 0;
  int n_bad = 0;
  logic ds_seen, fs_seen;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_top dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dev_irq(dev_irq), .mem_err(mem_err),
    .size_err(size_err), .tc_zero(tc_zero), .parity_err(parity_err),
    .irq_out(irq_out), .eng_reset(eng_reset), .eng_enable(eng_enable),
    .dir_to_mem(dir_to_mem), .burst_mode(burst_mode),
    .drain_stb(drain_stb), .flush_stb(flush_stb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_at(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; addr = 0;
    ds_seen = drain_stb; fs_seen = flush_stb;
  endtask

  task automatic rd_at(input logic [3:0] a, output logic [31:0] r);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; addr = 0;
    r = rd_data;
  endtask

  task automatic pulse(input logic e, input logic t, input logic p, input logic s);
    @(negedge clk); mem_err = e; tc_zero = t; parity_err = p; size_err = s;
    @(negedge clk); mem_err = 0; tc_zero = 0; parity_err = 0; size_err = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; addr = 0; wr_en = 0; rd_en = 0; wr_data = 0;
    dev_irq = 0; mem_err = 0; size_err = 0; tc_zero = 0; parity_err = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 outputs", {26'd0, irq_out, eng_reset, eng_enable, dir_to_mem, drain_stb, flush_stb}, 0);
    chk("R1 burst", {30'd0, burst_mode}, 0);
    rd_at(0, v); chk("R1 word", v, IDW);

    // R11 id read-only
    wr_at(0, 32'h5000_0000); rd_at(0, v); chk("R11 id", v, IDW);

    // R6 control bits
    wr_at(0, 32'h0004_A310); rd_at(0, v); chk("R6 rw", v, IDW | 32'h0004_A310);
    chk("R6 en/dir/rst", {29'd0, eng_enable, dir_to_mem, eng_reset}, 3'b110);
    wr_at(0, 32'h0000_0390);
    chk("R6 reset holds", {29'd0, eng_enable, dir_to_mem, eng_reset}, 3'b011);
    wr_at(0, 0); rd_at(0, v); chk("R6 clear", v, IDW);

    // R2 device interrupt follows line
    @(negedge clk); dev_irq = 1; @(negedge clk);
    rd_at(0, v); chk("R2 high", v, IDW | 32'h4001);
    dev_irq = 0; @(negedge clk);
    rd_at(0, v); chk("R2 low", v, IDW);

    // R3, R4 error then flush
    pulse(1, 1, 1, 0);
    rd_at(0, v); chk("R3 err set", v, IDW | 32'h0001_1002);
    wr_at(0, 32'h20); chk("R4 flush strobe", {31'd0, fs_seen}, 1);
    @(negedge clk); chk("R4 strobe one cycle", {31'd0, flush_stb}, 0);
    rd_at(0, v); chk("R4 cleared", v, IDW);

    // R5 clear-on-read, R12 foreign access
    pulse(0, 0, 0, 1);
    rd_at(1, v); chk("R12 foreign read", v, 0);
    rd_at(0, v); chk("R5 slave set", v, IDW | 32'h40);
    rd_at(0, v); chk("R5 slave cleared", v, IDW);
    wr_at(1, 32'h0000_0310); rd_at(0, v); chk("R12 foreign write", v, IDW);
    chk("R12 outputs", {30'd0, eng_enable, dir_to_mem}, 0);

    // R9 burst codes
    for (int b = 0; b < 4; b++) begin
      wr_at(0, 32'(b) << 20); rd_at(0, v);
      chk("R9 raw", v, IDW | (32'(b) << 20));
      chk("R9 decode", {30'd0, burst_mode}, (b == 3) ? 0 : 32'(b));
    end

    // R10 drain
    wr_at(0, 32'h0002_0000); chk("R10 drain strobe", {31'd0, ds_seen}, 1);
    @(negedge clk); chk("R10 one cycle", {31'd0, drain_stb}, 0);
    rd_at(0, v); chk("R10 reads 0", v, IDW);
    wr_at(0, 32'h0004_0000);
    wr_at(0, 32'h0006_0000); chk("R10 auto-drain blocks", {31'd0, ds_seen}, 0);
    wr_at(0, 0);

    // R7, R8 exhaustive interrupt sweep
    for (int k = 0; k < 128; k++) begin
      logic d, t, te, p, pe, e, ie, sum, irq;
      logic [31:0] c, exp;
      d = k[0]; t = k[1]; te = k[2]; p = k[3]; pe = k[4]; e = k[5]; ie = k[6];
      @(negedge clk); dev_irq = d;
      c = (32'(ie) << 4) | (32'(te) << 13) | (32'(pe) << 15);
      wr_at(0, c | 32'h20);
      pulse(e, t, p, 0);
      @(negedge clk);
      sum = d | (t & te) | (p & pe);
      irq = ie & (sum | e);
      chk("R8 irq_out", {31'd0, irq_out}, {31'd0, irq});
      rd_at(0, v);
      exp = IDW | c | 32'(d) | (32'(e) << 1) | (32'(t) << 12) | (32'(sum) << 14) | (32'(p) << 16);
      chk("R7 summary word", v, exp);
    end
    dev_irq = 0;
    finish_run();
  end
endmodule